// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block generates the internal address for one port of a synchronous memory. On every rising clock edge it samples three active-low controls and picks the address used for the access in the following cycle. It can take the external address bus, keep the address it already presents, step that address up by one, or jump back to the address captured by the last accepted load.

A separate shadow register keeps the most recent loaded address, so a burst can be replayed from its start without driving the external bus again. The counter has no link to chip-select, byte-lane, direction or output-enable controls. It advances whenever its own controls ask, even while the memory is deselected. The storage array and the data path sit outside this block.

Top module: `burst_addr_ctr`

## Requirements
- R1: After rst_ni is released, addr_o is all zeros and the repeat address is all zeros, so a repeat with no load yet performed yields address 0.
- R2: When rep_ni is low at a rising edge, addr_o becomes the stored repeat address, whatever load_ni and cnt_en_ni are.
- R3: When rep_ni is high and load_ni is low at a rising edge, addr_o becomes ext_addr_i, whatever cnt_en_ni is.
- R4: A load accepted under R3 also writes ext_addr_i into the repeat address. A low load_ni while rep_ni is low leaves the repeat address unchanged.
- R5: When rep_ni, load_ni and cnt_en_ni are all high at a rising edge, addr_o keeps its value.
- R6: When rep_ni and load_ni are high and cnt_en_ni is low at a rising edge, addr_o becomes its previous value plus one.
- R7: Incrementing the all-ones address gives all zeros (the count is modulo 2^ADDR_W).
- R8: Each of the eight combinations of the three controls gives the address that the priority order repeat, load, count, hold selects, one clock after sampling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; controls are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_addr_i | input | ADDR_W | External address bus |
| load_ni | input | 1 | Load strobe, active low |
| cnt_en_ni | input | 1 | Count enable, active low |
| rep_ni | input | 1 | Repeat strobe, active low |
| addr_o | output | ADDR_W | Internal address used for the current access |

## Verification
The bench builds the counter with ADDR_W set to 6. At that width the wrap from 63 to 0 can be reached within a few dozen count cycles, which leaves room to step through every control combination several times against a behavioural model. The narrow width also means an off-by-one in the increment or a wrong priority between repeat and load shows up within a short stimulus list.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_COUNT  = 2'd1,
    OP_LOAD   = 2'd2,
    OP_REPEAT = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/burst_ctr_decode.sv
module burst_ctr_decode
  import burst_ctr_pkg::*;
(
  input  logic    load_ni,
  input  logic    cnt_en_ni,
  input  logic    rep_ni,
  output ctr_op_e op_o
);
  // priority: repeat > load > count > hold
  always_comb begin
    if (!rep_ni)         op_o = OP_REPEAT;
    else if (!load_ni)   op_o = OP_LOAD;
    else if (!cnt_en_ni) op_o = OP_COUNT;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/burst_ctr_shadow.sv
module burst_ctr_shadow
  import burst_ctr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctr_op_e           op_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              shadow_o <= '0;
    else if (op_i == OP_LOAD) shadow_o <= ext_addr_i;
  end
endmodule

// File: rtl/burst_ctr_addr.sv
module burst_ctr_addr
  import burst_ctr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctr_op_e           op_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [ADDR_W-1:0] shadow_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] Step = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (op_i)
      OP_REPEAT: addr_d = shadow_i;
      OP_LOAD:   addr_d = ext_addr_i;
      OP_COUNT:  addr_d = addr_o + Step; // wraps naturally
      default:   addr_d = addr_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else         addr_o <= addr_d;
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_ctr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              load_ni,
  input  logic              cnt_en_ni,
  input  logic              rep_ni,
  output logic [ADDR_W-1:0] addr_o
);
  ctr_op_e           op;
  logic [ADDR_W-1:0] shadow_q;

  burst_ctr_decode u_decode (
    .load_ni   (load_ni),
    .cnt_en_ni (cnt_en_ni),
    .rep_ni    (rep_ni),
    .op_o      (op)
  );

  burst_ctr_shadow #(.ADDR_W(ADDR_W)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .ext_addr_i (ext_addr_i),
    .shadow_o   (shadow_q)
  );

  burst_ctr_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .ext_addr_i (ext_addr_i),
    .shadow_i   (shadow_q),
    .addr_o     (addr_o)
  );
endmodule

// File: rtl/burst_ctr_chk.sv
module burst_ctr_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              load_ni,
  input logic              cnt_en_ni,
  input logic              rep_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] shadow_q
);
  assert_reset_zero_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (addr_o == '0 && shadow_q == '0));

  assert_repeat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rep_ni |=> addr_o == $past(shadow_q));

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_ni && !load_ni) |=> addr_o == $past(ext_addr_i));

  assert_shadow_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_ni && !load_ni) |=> shadow_q == $past(ext_addr_i));

  assert_shadow_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rep_ni && !load_ni) |=> $stable(shadow_q));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_ni && load_ni && cnt_en_ni) |=> $stable(addr_o));

  assert_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_ni && load_ni && !cnt_en_ni) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_ni && load_ni && !cnt_en_ni && addr_o == '1) |=> addr_o == '0);
endmodule

bind burst_addr_ctr burst_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_addr_i (ext_addr_i),
  .load_ni    (load_ni),
  .cnt_en_ni  (cnt_en_ni),
  .rep_ni     (rep_ni),
  .addr_o     (addr_o),
  .shadow_q   (shadow_q)
);

// File: tb/tb_burst_addr_ctr.sv
`timescale 1ns/1ps
module tb_burst_addr_ctr;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          load_n = 1'b1;
  logic          cnt_n = 1'b1;
  logic          rep_n = 1'b1;
  logic [AW-1:0] addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_q[$];
  int            tag_q[$];
  logic [AW-1:0] m_addr = '0;
  logic [AW-1:0] m_shadow = '0;

  always #2 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_addr_i (ext_addr),
    .load_ni    (load_n),
    .cnt_en_ni  (cnt_n),
    .rep_ni     (rep_n),
    .addr_o     (addr)
  );

  task automatic check(input int req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d addr actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: drive at negedge, model the requirement, push expectation
  task automatic step(input logic l, input logic c, input logic r,
                      input logic [AW-1:0] a, input int req);
    @(negedge clk);
    load_n = l; cnt_n = c; rep_n = r; ext_addr = a;
    if (!r)      m_addr = m_shadow;
    else if (!l) begin m_addr = a; m_shadow = a; end
    else if (!c) m_addr = m_addr + 1'b1;
    exp_q.push_back(m_addr);
    tag_q.push_back(req);
  endtask

  // monitor: sample 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      int t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, addr, e);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, addr, '0);            // R1 reset value
    step(1, 1, 0, 6'd33, 1);       // R1 repeat before any load -> 0
    step(0, 1, 1, 6'd5, 3);        // R3 load
    step(1, 0, 1, 6'd9, 6);        // R6 count
    step(1, 0, 1, 6'd9, 6);        // R6
    step(1, 0, 1, 6'd9, 6);        // R6
    step(1, 1, 1, 6'd20, 5);       // R5 hold, ext ignored
    step(1, 1, 1, 6'd21, 5);       // R5
    step(1, 1, 0, 6'd22, 4);       // R4 repeat returns to 5
    step(0, 0, 1, 6'd40, 3);       // R3 load beats count
    step(0, 1, 0, 6'd10, 2);       // R2 repeat beats load -> 40
    step(1, 1, 0, 6'd11, 4);       // R4 shadow untouched by blocked load -> 40
    step(0, 1, 1, 6'd62, 3);       // R3
    step(1, 0, 1, 6'd0, 7);        // R7 63
    step(1, 0, 1, 6'd0, 7);        // R7 wrap to 0
    step(1, 0, 1, 6'd0, 7);        // R7 1
    step(1, 1, 0, 6'd0, 2);        // R2 back to 62
    for (int k = 0; k < 24; k++) begin
      step(k[0], k[1], k[2], AW'(k * 7 + 3), 8); // R8 all combinations
    end
    for (int k = 0; k < 70; k++) begin
      step(1, 0, 1, '0, 7);        // R7 full lap with wrap
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule